// File: doc/BRIEF.md
# Three-Phase Center-Aligned PWM Generator

This block drives a three-phase inverter bridge. A master period register sets the length of each switching cycle in system clocks. Three on-time registers set the pulse of phases A, B and C, and each pulse is placed symmetrically about the middle of the cycle. Every phase has a main output and a complementary output, both active low. A programmable dead time keeps the two switches of a leg from conducting together. A deletion threshold suppresses pulses too narrow for the power devices to follow.

Settings arrive through a simple write port. Code 0 is the period, codes 1, 2 and 3 are the on-times of phases A, B and C, code 4 is the dead time and code 5 is the deletion threshold. All settings are double-buffered and move into the running set at a commit point near the end of each cycle. The three on-times move only as a group, so the three legs never run with a mix of old and new duties. A one-clock sync pulse marks the first clock of each cycle and can trigger current sampling. A stop input forces all six gates off at once, with no clock edge between the input and the outputs.

Top module: `pwm3_gen`

## Requirements
- R1: While rst is high, all six gate outputs are high and sync is low. After reset the period is RST_PERIOD (64) clocks and all on-times, the dead time and the threshold are zero, so every main output stays inactive and every complementary output stays active.
- R2: sync is high for exactly one clock at position 0 of every cycle, and a cycle lasts P clocks. P is the committed period value, raised to MIN_PERIOD (8) if a smaller value was written.
- R3: For a phase with on-time T (0 < T < P), dead time D (the written value with bit 0 cleared) and position c in the cycle, the main output is active (low) when 2c >= P - T + 2D and 2c < P + T - 2D. The pulse is centred and each side is shortened by D clocks.
- R4: Under the same conditions as R3, the complementary output is active when 2c < P - T or 2c >= P + T. This leaves a gap of D clocks between each main edge and the nearest complementary edge.
- R5: An on-time T >= P makes the main output active and the complementary output inactive for the whole cycle.
- R6: An on-time of 0, or a main pulse width T - 2D below the deletion threshold (T < 2D + threshold), makes the main output inactive and the complementary output active for the whole cycle.
- R7: Writes to the on-time codes 1, 2 and 3 are taken up only after all three have been written since the last take-up. Writing only some of them leaves all three phases unchanged.
- R8: At the commit point, the settings that were written move into the running set, and the cycle after the commit point runs with them. A write sampled at least five clock edges before the edge that raises sync joins that next cycle. A write sampled four or fewer edges before it waits one more cycle.
- R9: The period (code 0), dead time (code 4) and threshold (code 5) are taken up at the next commit point whether or not any on-time was written.
- R10: While stop is high, all six gate outputs are high. Once stop is low, the outputs show the running pattern for the current position again, in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, sampled on the rising clock edge |
| wr_addr | input | 3 | Setting select: 0 period, 1-3 on-times of A-C, 4 dead time, 5 threshold |
| wr_data | input | 12 | Write value; dead time and threshold use the low 7 bits |
| stop | input | 1 | Forces all gate outputs inactive while high |
| hi_n | output | 3 | Main gate outputs of phases A, B, C, active low |
| lo_n | output | 3 | Complementary gate outputs of phases A, B, C, active low |
| sync | output | 1 | One-clock pulse at the first clock of each cycle |

## Verification
The assertions assume that rst is high from time zero and that MIN_PERIOD is at least 5. With that, the commit point and the wrap never fall on the same count, and syncs are always at least MIN_PERIOD clocks apart. They also assume that the two outputs of a leg are never both driven active, which holds only if the dead-time and deletion settings reach the legs as one consistent set. The stimulus changes writes and stop only at falling clock edges. It never writes while a settings group is half delivered, except in the tests that target atomic take-up and the commit deadline. It waits two sync pulses after each full set of writes, so every compared cycle runs on a known, fully committed configuration.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;

    localparam int CNT_W  = 12;
    localparam int DT_W   = 7;
    localparam int NPH    = 3;
    localparam int ADDR_W = 3;
    localparam int BND_W  = CNT_W + 3;

    typedef enum logic [ADDR_W-1:0] {
        ADDR_PERIOD = 3'd0,
        ADDR_ON_A   = 3'd1,
        ADDR_ON_B   = 3'd2,
        ADDR_ON_C   = 3'd3,
        ADDR_DEAD   = 3'd4,
        ADDR_DEL    = 3'd5
    } reg_addr_e;

    // One complete setting group, shadow or committed
    typedef struct packed {
        logic [NPH-1:0][CNT_W-1:0] on;
        logic [CNT_W-1:0]          period;
        logic [DT_W-1:0]           dead;
        logic [DT_W-1:0]           del;
    } cfg_t;

    // Per-leg compare thresholds, expressed in doubled count units
    typedef struct packed {
        logic                    full_on;
        logic                    full_off;
        logic signed [BND_W-1:0] m_lo;
        logic signed [BND_W-1:0] m_hi;
        logic signed [BND_W-1:0] c_lo;
        logic signed [BND_W-1:0] c_hi;
    } edges_t;

    localparam edges_t EDGES_IDLE = '{full_on: 1'b0, full_off: 1'b1, default: '0};

    function automatic edges_t calc_edges(
        input logic [CNT_W-1:0] per,
        input logic [CNT_W-1:0] on,
        input logic [DT_W-1:0]  dead,
        input logic [DT_W-1:0]  del
    );
        edges_t                  e;
        logic [DT_W-1:0]         d_even;
        logic signed [BND_W-1:0] p_s;
        logic signed [BND_W-1:0] t_s;
        logic signed [BND_W-1:0] d2_s;
        logic [CNT_W+1:0]        thr;
        d_even     = dead & ~DT_W'(1);
        p_s        = $signed(BND_W'(per));
        t_s        = $signed(BND_W'(on));
        d2_s       = $signed(BND_W'({d_even, 1'b0}));
        thr        = (CNT_W+2)'({d_even, 1'b0}) + (CNT_W+2)'(del);
        e.full_on  = (on >= per);
        e.full_off = !e.full_on && ((on == '0) || ((CNT_W+2)'(on) < thr));
        e.m_lo     = p_s - t_s + d2_s;
        e.m_hi     = p_s + t_s - d2_s;
        e.c_lo     = p_s - t_s;
        e.c_hi     = p_s + t_s;
        return e;
    endfunction

endpackage

// File: rtl/pwm3_cfg.sv
module pwm3_cfg
    import pwm3_pkg::*;
#(
    parameter int RST_PERIOD = 64,
    parameter int MIN_PERIOD = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic              commit,
    output cfg_t              nxt
);

    localparam cfg_t CFG_RST = '{on: '0, period: CNT_W'(RST_PERIOD), dead: '0, del: '0};
    localparam logic [CNT_W-1:0] PER_MIN = CNT_W'(MIN_PERIOD);

    cfg_t             shadow;
    logic [NPH-1:0]   pend;
    logic [NPH-1:0]   pend_d;
    logic [NPH-1:0]   hit;
    logic [CNT_W-1:0] per_cl;

    always_comb begin
        for (int i = 0; i < NPH; i++) begin
            hit[i] = wr_en && (wr_addr == ADDR_W'(int'(ADDR_ON_A) + i));
        end
        // a complete group is consumed at the commit point; new writes rearm
        pend_d = (commit && (&pend)) ? hit : (pend | hit);
        per_cl = (shadow.period < PER_MIN) ? PER_MIN : shadow.period;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow <= CFG_RST;
            nxt    <= CFG_RST;
            pend   <= '0;
        end else begin
            pend <= pend_d;
            if (wr_en) begin
                case (reg_addr_e'(wr_addr))
                    ADDR_PERIOD: shadow.period <= wr_data;
                    ADDR_DEAD:   shadow.dead   <= wr_data[DT_W-1:0];
                    ADDR_DEL:    shadow.del    <= wr_data[DT_W-1:0];
                    default:     ;
                endcase
            end
            for (int i = 0; i < NPH; i++) begin
                if (hit[i]) shadow.on[i] <= wr_data;
            end
            if (commit) begin
                nxt.period <= per_cl;
                nxt.dead   <= shadow.dead;
                nxt.del    <= shadow.del;
                if (&pend) nxt.on <= shadow.on;
            end
        end
    end

endmodule

// File: rtl/pwm3_timer.sv
module pwm3_timer
    import pwm3_pkg::*;
#(
    parameter int RST_PERIOD = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] nxt_period,
    output logic [CNT_W-1:0] cnt,
    output logic             commit,
    output logic             wrap
);

    localparam int LEAD = 4;

    logic [CNT_W-1:0] per_q;

    assign wrap   = (cnt == per_q - CNT_W'(1));
    assign commit = (cnt == per_q - CNT_W'(LEAD));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            per_q <= CNT_W'(RST_PERIOD);
        end else if (wrap) begin
            cnt   <= '0;
            per_q <= nxt_period;
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/pwm3_leg.sv
module pwm3_leg
    import pwm3_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] on_time,
    input  logic [DT_W-1:0]  dead,
    input  logic [DT_W-1:0]  del,
    input  logic             wrap,
    input  logic [CNT_W-1:0] cnt,
    output logic             main_q,
    output logic             comp_q
);

    edges_t                  act;
    edges_t                  e_new;
    logic signed [BND_W-1:0] pos2;
    logic                    main_c;
    logic                    comp_c;

    assign e_new = calc_edges(period, on_time, dead, del);
    assign pos2  = $signed(BND_W'({cnt, 1'b0}));

    always_comb begin
        main_c = act.full_on ||
                 (!act.full_off && (pos2 >= act.m_lo) && (pos2 < act.m_hi));
        comp_c = !act.full_on &&
                 (act.full_off || (pos2 < act.c_lo) || (pos2 >= act.c_hi));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act    <= EDGES_IDLE;
            main_q <= 1'b0;
            comp_q <= 1'b0;
        end else begin
            if (wrap) act <= e_new;
            main_q <= main_c;
            comp_q <= comp_c;
        end
    end

endmodule

// File: rtl/pwm3_gen.sv
module pwm3_gen
    import pwm3_pkg::*;
#(
    parameter int RST_PERIOD = 64,
    parameter int MIN_PERIOD = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic              stop,
    output logic [NPH-1:0]    hi_n,
    output logic [NPH-1:0]    lo_n,
    output logic              sync
);

    cfg_t             nxt;
    logic [CNT_W-1:0] cnt;
    logic             commit;
    logic             wrap;
    logic [NPH-1:0]   main_q;
    logic [NPH-1:0]   comp_q;
    logic             sync_q;

    pwm3_cfg #(.RST_PERIOD(RST_PERIOD), .MIN_PERIOD(MIN_PERIOD)) u_cfg (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .commit(commit), .nxt(nxt)
    );

    pwm3_timer #(.RST_PERIOD(RST_PERIOD)) u_timer (
        .clk(clk), .rst(rst), .nxt_period(nxt.period),
        .cnt(cnt), .commit(commit), .wrap(wrap)
    );

    for (genvar g = 0; g < NPH; g++) begin : g_leg
        pwm3_leg u_leg (
            .clk(clk), .rst(rst), .period(nxt.period), .on_time(nxt.on[g]),
            .dead(nxt.dead), .del(nxt.del), .wrap(wrap), .cnt(cnt),
            .main_q(main_q[g]), .comp_q(comp_q[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) sync_q <= 1'b0;
        else     sync_q <= (cnt == '0);
    end

    assign sync = sync_q;
    assign hi_n = ~main_q | {NPH{stop}};
    assign lo_n = ~comp_q | {NPH{stop}};

endmodule

// File: rtl/pwm3_gen_chk.sv
module pwm3_gen_chk
    import pwm3_pkg::*;
#(
    parameter int MIN_PERIOD = 8
) (
    input logic           clk,
    input logic           rst,
    input logic           stop,
    input logic           sync,
    input logic [NPH-1:0] hi_n,
    input logic [NPH-1:0] lo_n
);

    logic [CNT_W:0] gap;
    logic           seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap  <= '0;
            seen <= 1'b0;
        end else if (sync) begin
            gap  <= '0;
            seen <= 1'b1;
        end else if (gap != '1) begin
            gap <= gap + 1'b1;
        end
    end

    // R2
    sync_single_chk: assert property (@(posedge clk) disable iff (rst)
        sync |=> !sync);

    // R2
    sync_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        (sync && seen) |-> (gap >= (CNT_W+1)'(MIN_PERIOD - 1)));

    // R10
    stop_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        stop |-> ((&hi_n) && (&lo_n)));

    for (genvar g = 0; g < NPH; g++) begin : g_pair
        // R4
        pair_excl_chk: assert property (@(posedge clk) disable iff (rst)
            !(!hi_n[g] && !lo_n[g]));
    end

endmodule

bind pwm3_gen pwm3_gen_chk #(.MIN_PERIOD(MIN_PERIOD)) u_chk (
    .clk(clk), .rst(rst), .stop(stop), .sync(sync), .hi_n(hi_n), .lo_n(lo_n)
);

// File: tb/tb_pwm3_gen.sv
module tb_pwm3_gen;

    localparam int CLK_PERIOD = 10;
    localparam int MINP       = 8;

    typedef struct packed {
        int p; int ta; int tb; int tc; int dt; int pd;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{20, 10,    5,  0, 0,  0},
        '{20, 10,   14, 20, 2,  0},
        '{24, 12, 4095,  6, 5,  0},
        '{30, 14,   13,  9, 2, 10},
        '{16,  1,   15, 16, 0,  1},
        '{21,  7,    8, 20, 2,  3}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [11:0] wr_data = '0;
    logic        stop = 1'b0;
    logic [2:0]  hi_n;
    logic [2:0]  lo_n;
    logic        sync;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm3_gen dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .stop(stop), .hi_n(hi_n), .lo_n(lo_n), .sync(sync)
    );

    function automatic int eff_p(int p);
        return (p < MINP) ? MINP : p;
    endfunction

    function automatic bit cut(int t, int dt, int pd);
        int d = dt & ~1;
        return (t == 0) || (t < 2*d + pd);
    endfunction

    function automatic bit exp_main(int p, int t, int dt, int pd, int c);
        int d = dt & ~1;
        if (t >= p) return 1'b1;
        if (cut(t, dt, pd)) return 1'b0;
        return (2*c >= p - t + 2*d) && (2*c < p + t - 2*d);
    endfunction

    function automatic bit exp_comp(int p, int t, int dt, int pd, int c);
        if (t >= p) return 1'b0;
        if (cut(t, dt, pd)) return 1'b1;
        return (2*c < p - t) || (2*c >= p + t);
    endfunction

    function automatic string tag_of(int p, int t, int dt, int pd, bit is_main);
        if (t >= p) return "R5";
        if (cut(t, dt, pd)) return "R6";
        return is_main ? "R3" : "R4";
    endfunction

    task automatic chk(input bit ok, input string req, input int got, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at %0t: got=%0d exp=%0d", req, $time, got, exp);
        end
    endtask

    task automatic wr(input int addr, input int data);
        wr_en   = 1'b1;
        wr_addr = 3'(addr);
        wr_data = 12'(data);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic wait_sync();
        do @(negedge clk); while (!sync);
    endtask

    // compares one full cycle from position 0; returns at position 0 of the next cycle
    task automatic check_cycle(input string ctx, input int p_raw, input int ta,
                               input int tb, input int tc, input int dt, input int pd);
        int p = eff_p(p_raw);
        for (int k = 0; k < p; k++) begin
            if (k > 0) @(negedge clk);
            chk(sync == (k == 0), {ctx, " R2 sync"}, int'(sync), int'(k == 0));
            for (int ph = 0; ph < 3; ph++) begin
                int t = (ph == 0) ? ta : (ph == 1) ? tb : tc;
                bit em = exp_main(p, t, dt, pd, k);
                bit ec = exp_comp(p, t, dt, pd, k);
                chk(!hi_n[ph] == em, {ctx, " ", tag_of(p, t, dt, pd, 1'b1), " main"},
                    int'(!hi_n[ph]), int'(em));
                chk(!lo_n[ph] == ec, {ctx, " ", tag_of(p, t, dt, pd, 1'b0), " comp"},
                    int'(!lo_n[ph]), int'(ec));
            end
        end
        @(negedge clk);
        chk(sync == 1'b1, {ctx, " R2 period end"}, int'(sync), 1);
    endtask

    task automatic apply(input vec_t v);
        wr(0, v.p); wr(1, v.ta); wr(2, v.tb); wr(3, v.tc); wr(4, v.dt); wr(5, v.pd);
        wait_sync();
        wait_sync();
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        // R1: reset state
        repeat (4) @(negedge clk);
        chk(hi_n == 3'b111, "R1 hi_n in reset", int'(hi_n), 7);
        chk(lo_n == 3'b111, "R1 lo_n in reset", int'(lo_n), 7);
        chk(sync == 1'b0, "R1 sync in reset", int'(sync), 0);
        rst = 1'b0;
        wait_sync();
        check_cycle("R1", 64, 0, 0, 0, 0, 0);

        // table walk: R3 R4 R5 R6
        for (int i = 0; i < 6; i++) begin
            apply(VECS[i]);
            check_cycle("vec", VECS[i].p, VECS[i].ta, VECS[i].tb, VECS[i].tc,
                        VECS[i].dt, VECS[i].pd);
        end

        // R8: commit deadline, P = 20
        apply('{20, 4, 4, 4, 0, 0});
        wr(1, 10); wr(2, 10);
        repeat (13) @(negedge clk);
        wr(3, 10);                       // sampled four edges before sync edge
        wait_sync();
        check_cycle("R8 late", 20, 4, 4, 4, 0, 0);
        check_cycle("R8 applied", 20, 10, 10, 10, 0, 0);
        wr(1, 6); wr(2, 6);
        repeat (12) @(negedge clk);
        wr(3, 6);                        // sampled five edges before sync edge
        wait_sync();
        check_cycle("R8 in time", 20, 6, 6, 6, 0, 0);

        // R7: partial on-time group is held back
        wr(1, 16); wr(2, 16);
        wait_sync();
        check_cycle("R7 partial", 20, 6, 6, 6, 0, 0);
        check_cycle("R7 partial", 20, 6, 6, 6, 0, 0);
        wr(3, 16);
        wait_sync();
        check_cycle("R7 complete", 20, 16, 16, 16, 0, 0);

        // R10: stop forces all outputs high, release resumes at once
        repeat (5) @(negedge clk);
        stop = 1'b1;
        #1;
        chk((hi_n == 3'b111) && (lo_n == 3'b111), "R10 stop asserted",
            int'({hi_n, lo_n}), 63);
        @(negedge clk);
        chk((hi_n == 3'b111) && (lo_n == 3'b111), "R10 stop held",
            int'({hi_n, lo_n}), 63);
        @(negedge clk);
        @(negedge clk);
        stop = 1'b0;
        #1;
        chk(hi_n == 3'b000, "R10 resume main", int'(hi_n), 0);
        chk(lo_n == 3'b111, "R10 resume comp", int'(lo_n), 7);
        wait_sync();

        // R9: period alone loads, then clamp to the minimum (R2)
        wr(0, 24);
        wait_sync();
        check_cycle("R9 period only", 24, 16, 16, 16, 0, 0);
        wr(0, 3);
        wait_sync();
        check_cycle("R9 R2 clamp", 3, 16, 16, 16, 0, 0);

        done = 1'b1;
        finish_run();
    end

endmodule